// File: doc/BRIEF.md
# Addressed Serial Attenuation Register

This block takes a 16-bit frame on three asynchronous lines: serial data, serial clock and latch enable. It shifts the frame into a holding register and passes an 8-bit attenuation word to a downstream mode selector, but only after a latch pulse and only when the frame carries this block's address. Several copies can share one set of serial lines. Each copy compares the frame's address field with a 3-bit address strapped on its own static pins, and only the copy with the matching address takes the new word.

All three serial lines cross into the system clock domain through two-flop synchronizers. Rising edges of the serial clock and falling edges of the latch enable are then detected with one extra flop per line. Bits 6 to 0 of the attenuation word form a 7-bit code of 0.25 dB per step, so code 127 means 31.75 dB. Bit 7 is passed through unchanged, and in normal use it is expected to be low.

Top module: `addr_atten_reg`

## Requirements
- R1: While reset is asserted and after it is released, `atten_word` is 8'h7F (maximum attenuation, 31.75 dB) and `update_strobe` is low.
- R2: Bits are taken least significant bit first. The first 8 bits of a frame are attenuation bits 0 to 7, and the next 8 bits are address bits 0 to 7.
- R3: When latch enable falls and address bits 2:0 of the frame equal `addr_pins`, all 8 bits of the frame's attenuation word appear on `atten_word`, including bit 7.
- R4: When latch enable falls and address bits 2:0 differ from `addr_pins`, `atten_word` keeps its value and `update_strobe` stays low.
- R5: Address bits 7:3 have no effect on the compare.
- R6: Serial clock rising edges seen while latch enable is high do not shift the register. `atten_word` does not change while bits are shifted with latch enable low.
- R7: If more than 16 bits are shifted before a latch pulse, only the last 16 are kept.
- R8: `update_strobe` is high for exactly one system clock cycle for each committed word. It is high in the same cycle that `atten_word` takes the new value, and `atten_word` changes at no other time.
- R9: Serial data is sampled on serial clock rising edges after a two-flop synchronizer. A commit becomes visible no more than 5 system clock cycles after latch enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock, asynchronous |
| sdata_in | input | 1 | Serial data, asynchronous |
| latch_in | input | 1 | Latch enable, asynchronous |
| addr_pins | input | 3 | Strapped device address |
| atten_word | output | 8 | Committed attenuation word |
| update_strobe | output | 1 | One-cycle pulse on commit |

## Verification
The bench sends frames whose upper address bits are set while the low bits still match. A design that compared all 8 address bits would drop those words. It also shifts four junk bits ahead of a valid frame, which catches a register that keeps the oldest bits or counts to 16 and stops. Serial clock pulses are sent while latch enable is high, and a design that shifted during the latch would commit a corrupted word. The bench also changes the strapped address between frames and sends a word with bit 7 set, which exposes a compare on the wrong field and a dropped top bit.

// File: rtl/addr_atten_reg.sv
module addr_atten_reg #(
  parameter int ATTEN_W     = 8,
  parameter int ADDRW_W     = 8,
  parameter int ADDR_BITS   = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [ATTEN_W-1:0] RESET_ATTEN = 8'h7F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_in,
  input  logic                 sdata_in,
  input  logic                 latch_in,
  input  logic [ADDR_BITS-1:0] addr_pins,
  output logic [ATTEN_W-1:0]   atten_word,
  output logic                 update_strobe
);
  localparam int FRAME_W = ATTEN_W + ADDRW_W;

  logic [SYNC_STAGES:0] sclk_p, le_p;
  logic [SYNC_STAGES-1:0] sd_p;
  logic [FRAME_W-1:0] shreg;

  wire sclk_rise = sclk_p[SYNC_STAGES-1] & ~sclk_p[SYNC_STAGES];
  wire le_hi     = le_p[SYNC_STAGES-1];
  wire le_fall   = ~le_p[SYNC_STAGES-1] & le_p[SYNC_STAGES];
  wire addr_ok   = shreg[ATTEN_W +: ADDR_BITS] == addr_pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      le_p   <= '0;
      sd_p   <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-1:0], sclk_in};
      le_p   <= {le_p[SYNC_STAGES-1:0], latch_in};
      sd_p   <= {sd_p[SYNC_STAGES-2:0], sdata_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shreg <= '0;
    else if (sclk_rise && !le_hi)
      shreg <= {sd_p[SYNC_STAGES-1], shreg[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atten_word    <= RESET_ATTEN;
      update_strobe <= 1'b0;
    end else begin
      update_strobe <= le_fall && addr_ok;
      if (le_fall && addr_ok)
        atten_word <= shreg[ATTEN_W-1:0];
    end
  end
endmodule

// File: rtl/addr_atten_reg_chk.sv
module addr_atten_reg_chk #(
  parameter int ATTEN_W   = 8,
  parameter int ADDR_BITS = 3,
  parameter int FRAME_W   = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 le_sync,
  input logic [FRAME_W-1:0]   shreg,
  input logic [ADDR_BITS-1:0] addr_pins,
  input logic [ATTEN_W-1:0]   atten_word,
  input logic                 update_strobe
);
  assert_freeze_in_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    le_sync |=> $stable(shreg));

  assert_match_needed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    update_strobe |-> $past(shreg[ATTEN_W +: ADDR_BITS]) == $past(addr_pins));

  assert_commit_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    update_strobe |-> atten_word == $past(shreg[ATTEN_W-1:0]));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    update_strobe |=> !update_strobe);

  assert_out_only_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !update_strobe |-> $stable(atten_word));
endmodule

bind addr_atten_reg addr_atten_reg_chk #(
  .ATTEN_W(ATTEN_W), .ADDR_BITS(ADDR_BITS), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .le_sync(le_p[SYNC_STAGES-1]), .shreg(shreg),
  .addr_pins(addr_pins), .atten_word(atten_word), .update_strobe(update_strobe)
);

// File: tb/tb_addr_atten_reg.sv
module tb_addr_atten_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, le = 1'b0;
  logic [2:0] pins = 3'b101;
  logic [7:0] atten_word;
  logic update_strobe;

  int checks = 0, errors = 0, strobes = 0, pushes = 0;
  logic [7:0] exp_q[$];
  logic [7:0] model = 8'h7F;
  localparam int HALF = 4;

  always #2.5 clk = ~clk;

  addr_atten_reg dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .sdata_in(sdata), .latch_in(le),
    .addr_pins(pins), .atten_word(atten_word), .update_strobe(update_strobe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      sdata = bits[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic latch_pulse(input int extra_sclk);
    le = 1'b1;
    wait_clk(HALF);
    for (int i = 0; i < extra_sclk; i++) begin
      sdata = 1'b1;
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    le = 1'b0;
    wait_clk(5);
  endtask

  task automatic frame(input logic [7:0] att, input logic [7:0] adr, input bit match,
                       input int junk, input int extra_sclk);
    int s0;
    if (junk > 0) send_bits(32'hFFFF_FFFF, junk);
    send_bits({16'h0, adr, att}, 16);
    check("R6 output held during shift", atten_word, model);
    s0 = strobes;
    if (match) begin
      exp_q.push_back(att);
      pushes++;
      model = att;
    end
    latch_pulse(extra_sclk);
    wait_clk(4);
    if (!match) begin
      check("R4 mismatch keeps output", atten_word, model);
      check("R4 mismatch no strobe", 8'(strobes - s0), 8'd0);
    end else begin
      check("R9 committed within latency", atten_word, att);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && update_strobe) begin
      strobes++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected strobe: actual %h expected none", atten_word);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (atten_word !== e) begin
          errors++;
          $display("FAIL R3 strobe word: actual %h expected %h", atten_word, e);
        end
      end
    end
  end

  initial begin
    wait_clk(3);
    check("R1 reset word", atten_word, 8'h7F);
    check("R1 reset strobe", {7'd0, update_strobe}, 8'd0);
    rst_n = 1'b1;
    wait_clk(4);
    check("R1 word after reset", atten_word, 8'h7F);

    frame(8'h2A, 8'h05, 1'b1, 0, 0);   // R2 R3
    frame(8'h00, 8'h04, 1'b0, 0, 0);   // R4
    frame(8'h13, 8'hFD, 1'b1, 0, 0);   // R5 upper address bits set
    frame(8'hC1, 8'h35, 1'b1, 0, 0);   // R3 bit 7 carried
    frame(8'h55, 8'h05, 1'b1, 4, 0);   // R7 leading junk bits dropped
    frame(8'h3C, 8'h05, 1'b1, 0, 5);   // R6 sclk pulses while latched
    pins = 3'b010;
    frame(8'h66, 8'h05, 1'b0, 0, 0);   // R4 old address rejected
    frame(8'h66, 8'h02, 1'b1, 0, 0);   // R3 new address
    pins = 3'b000;
    frame(8'h01, 8'hF8, 1'b1, 0, 0);   // R5 zero address with high bits
    frame(8'h7F, 8'h01, 1'b0, 0, 0);   // R4

    wait_clk(10);
    check("R8 one strobe per commit", 8'(strobes), 8'(pushes));
    check("R8 no pending commits", 8'(exp_q.size()), 8'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule